// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block lets a host with a 32-bit word interface drive an 8-bit raw NAND flash device. The host writes a control word whose top bits select the kind of flash bus cycle and the chip-enable level, and whose third byte carries the data. The bridge turns each such write into one timed command, address or data byte cycle on the flash pins. Strobe low times and latch setup and hold times are parameters counted in system clocks.

Reads take two steps. A control write with the read opcode starts no bus cycle; it arms read mode. After that, every host read of the data register issues one read-enable strobe and returns the captured byte. The flash ready/busy line passes through a two-flop synchronizer and can be read back as a status bit.

The host side is a request/acknowledge handshake. The host holds `host_req` and its qualifiers until `host_ack` pulses, so the host waits until the flash cycle behind the access has finished.

Top module: `nand_bridge`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_we_n` and `fl_re_n` are high and `fl_cle`, `fl_ale` and `fl_dq_oe` are low. A read of the control/status register (`host_addr`=0) returns 0 while the flash is ready.
- R2: A control write (`host_addr`=0, `host_we`=1) with opcode 0 in bits 30:28 produces exactly one WE# pulse. During that pulse CLE is high, ALE is low, and `fl_dq_o` carries bits 23:16 of the written word.
- R3: A control write with opcode 1 produces exactly one WE# pulse with ALE high and CLE low. CLE and ALE are never high together.
- R4: A control write with opcode 3 produces exactly one WE# pulse with CLE and ALE both low and bits 23:16 on `fl_dq_o`. `fl_dq_oe` is high throughout every WE# low phase.
- R5: Bit 31 of the last control write sets the chip enable. A 1 drives `fl_ce_n` low and a 0 drives it high. The level holds until the next control write and does not change while a bus cycle is running.
- R6: WE# stays low for exactly `WE_LOW_CLKS` clocks and RE# for exactly `RE_LOW_CLKS` clocks. The data bus is driven for exactly `SETUP_CLKS` clocks before WE# falls and `HOLD_CLKS` clocks after it rises, and CLE, ALE and data stay stable across the rise. WE# and RE# are never low together.
- R7: A control write with opcode 2 starts no strobe and arms read mode. While read mode is armed, each read of the data register (`host_addr`=1) gives exactly one RE# pulse and returns the flash byte in bits 23:16, with all other bits zero.
- R8: A read of the data register while read mode is not armed starts no strobe and returns 0.
- R9: A read of the control/status register returns the stored enable in bit 31, the stored opcode in bits 30:28, and in bit 15 a 1 while `fl_rb_n` (synchronized through two flops) shows busy (low), else 0. All other bits read 0.
- R10: `host_ack` is a one-clock pulse. It comes only when no strobe is low and the data bus is released, so it always follows the end of any bus cycle started by the access.
- R11: `fl_dq_oe` is low during RE# low phases and outside write cycles.
- R12: A control write with opcode 4 to 7 starts no strobe, stores its enable and opcode, and disarms read mode. Any write to the data register starts no strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 1 | 0 = control/status register, 1 = read data register |
| host_wdata | input | 32 | Write word: bit 31 enable, 30:28 opcode, 23:16 data byte |
| host_rdata | output | 32 | Read word, valid with `host_ack` |
| host_ack | output | 1 | One-clock completion pulse |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Output enable for the flash data bus |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The assertions assume the host keeps `host_req`, `host_we`, `host_addr` and `host_wdata` steady from request until it sees `host_ack`, then drops the request. They also assume every timing parameter is at least one. The bench's transfer task raises the request at a falling edge, holds every qualifier until the acknowledge is seen, and lowers the request right away. `fl_rb_n` is only changed at falling edges and held for several clocks, so the two-flop delay of the status bit is observed fully.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int EN_BIT   = 31;
  localparam int OP_MSB   = 30;
  localparam int OP_LSB   = 28;
  localparam int BYTE_LSB = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [2:0] OP_CMD   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_RDARM = 3'd2;
  localparam logic [2:0] OP_DATA  = 3'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STROBE, SQ_HOLD} seq_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/nbr_rb_sync.sv
module nbr_rb_sync (
  input  logic clk,
  input  logic rst,
  input  logic rb_n,
  output logic busy
);
  logic s1, s2;
  logic [1:0] settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      settle <= 2'd0;
    end else begin
      s1 <= rb_n;
      s2 <= s1;
      if (settle != 2'd2) settle <= settle + 2'd1;
    end
  end

  assign busy = ~s2;

  // R9: the busy flag follows the pin with a two-clock delay
  p_sync_lat_r9: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd2) |-> (busy == !$past(rb_n, 2)));
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
  import nbr_pkg::*;
#(
  parameter int SETUP_CLKS  = 2,
  parameter int WE_LOW_CLKS = 3,
  parameter int RE_LOW_CLKS = 3,
  parameter int HOLD_CLKS   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rd,
  input  logic       cle_in,
  input  logic       ale_in,
  input  logic [7:0] wbyte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rbyte,
  output logic       fl_cle,
  output logic       fl_ale,
  output logic       fl_we_n,
  output logic       fl_re_n,
  output logic [7:0] fl_dq_o,
  output logic       fl_dq_oe,
  input  logic [7:0] fl_dq_i
);
  localparam int MAXC = max4(SETUP_CLKS, WE_LOW_CLKS, RE_LOW_CLKS, HOLD_CLKS);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t     state;
  logic [CW-1:0]  cnt;
  logic           rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      rd_q     <= 1'b0;
      fl_cle   <= 1'b0;
      fl_ale   <= 1'b0;
      fl_we_n  <= 1'b1;
      fl_re_n  <= 1'b1;
      fl_dq_o  <= 8'h00;
      fl_dq_oe <= 1'b0;
      rbyte    <= 8'h00;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state    <= SQ_SETUP;
            cnt      <= CW'(SETUP_CLKS - 1);
            rd_q     <= rd;
            fl_cle   <= cle_in & ~rd;
            fl_ale   <= ale_in & ~rd;
            fl_dq_o  <= wbyte;
            fl_dq_oe <= ~rd;
          end
        end
        SQ_SETUP: begin
          if (cnt == '0) begin
            state <= SQ_STROBE;
            if (rd_q) begin
              fl_re_n <= 1'b0;
              cnt     <= CW'(RE_LOW_CLKS - 1);
            end else begin
              fl_we_n <= 1'b0;
              cnt     <= CW'(WE_LOW_CLKS - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_STROBE: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            fl_re_n <= 1'b1;
            if (rd_q) rbyte <= fl_dq_i;
            state <= SQ_HOLD;
            cnt   <= CW'(HOLD_CLKS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_HOLD: begin
          if (cnt == '0) begin
            state    <= SQ_IDLE;
            fl_cle   <= 1'b0;
            fl_ale   <= 1'b0;
            fl_dq_oe <= 1'b0;
            done     <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);

  // R6: the two strobes never overlap
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));
  // R3: command and address latch never together
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));
  // R4: data is driven while WE# is low
  p_drive_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_dq_oe);
  // R11: bus released during a read strobe
  p_no_drive_on_read_r11: assert property (@(posedge clk) disable iff (rst)
    !fl_re_n |-> !fl_dq_oe);
  // R6: latches and data held across the WE# rise
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_cle) && $stable(fl_ale) && $stable(fl_dq_o)));
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nbr_pkg::*;
#(
  parameter int SETUP_CLKS  = 2,
  parameter int WE_LOW_CLKS = 3,
  parameter int RE_LOW_CLKS = 3,
  parameter int HOLD_CLKS   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_req,
  input  logic        host_we,
  input  logic        host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ack,
  output logic        fl_ce_n,
  output logic        fl_cle,
  output logic        fl_ale,
  output logic        fl_we_n,
  output logic        fl_re_n,
  output logic [7:0]  fl_dq_o,
  output logic        fl_dq_oe,
  input  logic [7:0]  fl_dq_i,
  input  logic        fl_rb_n
);
  logic [2:0] op_w;
  logic [7:0] byte_w;
  logic       accept, wr_ctrl, rd_go, cyc_op, seq_start;
  logic       seq_busy, seq_done, flash_busy;
  logic [7:0] seq_rbyte;
  logic       en_q, rd_mode_q, hs_wait, wait_rd;
  logic [2:0] op_q;
  logic       unused_bits;

  assign op_w        = host_wdata[OP_MSB:OP_LSB];
  assign byte_w      = host_wdata[BYTE_LSB+7:BYTE_LSB];
  assign unused_bits = ^{host_wdata[27:24], host_wdata[15:0]};

  assign accept    = host_req && !host_ack && !hs_wait;
  assign wr_ctrl   = accept && host_we && !host_addr;
  assign rd_go     = accept && !host_we && host_addr && rd_mode_q;
  assign cyc_op    = (op_w == OP_CMD) || (op_w == OP_ADDR) || (op_w == OP_DATA);
  assign seq_start = (wr_ctrl && cyc_op) || rd_go;

  nbr_rb_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .rb_n (fl_rb_n),
    .busy (flash_busy)
  );

  nbr_seq #(
    .SETUP_CLKS  (SETUP_CLKS),
    .WE_LOW_CLKS (WE_LOW_CLKS),
    .RE_LOW_CLKS (RE_LOW_CLKS),
    .HOLD_CLKS   (HOLD_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (seq_start),
    .rd       (rd_go),
    .cle_in   (op_w == OP_CMD),
    .ale_in   (op_w == OP_ADDR),
    .wbyte    (byte_w),
    .busy     (seq_busy),
    .done     (seq_done),
    .rbyte    (seq_rbyte),
    .fl_cle   (fl_cle),
    .fl_ale   (fl_ale),
    .fl_we_n  (fl_we_n),
    .fl_re_n  (fl_re_n),
    .fl_dq_o  (fl_dq_o),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_i  (fl_dq_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      op_q       <= 3'd0;
      rd_mode_q  <= 1'b0;
      hs_wait    <= 1'b0;
      wait_rd    <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= 32'h0;
      fl_ce_n    <= 1'b1;
    end else begin
      host_ack <= 1'b0;
      if (hs_wait) begin
        if (seq_done) begin
          hs_wait    <= 1'b0;
          host_ack   <= 1'b1;
          host_rdata <= wait_rd ? {8'h00, seq_rbyte, 16'h0000} : 32'h0;
        end
      end else if (accept) begin
        if (host_we) begin
          host_rdata <= 32'h0;
          if (!host_addr) begin
            en_q      <= host_wdata[EN_BIT];
            fl_ce_n   <= ~host_wdata[EN_BIT];
            op_q      <= op_w;
            rd_mode_q <= (op_w == OP_RDARM);
          end
          if (seq_start) begin
            hs_wait <= 1'b1;
            wait_rd <= 1'b0;
          end else begin
            host_ack <= 1'b1;
          end
        end else if (!host_addr) begin
          host_rdata <= {en_q, op_q, 12'h000, flash_busy, 15'h0000};
          host_ack   <= 1'b1;
        end else if (rd_mode_q) begin
          hs_wait <= 1'b1;
          wait_rd <= 1'b1;
        end else begin
          host_rdata <= 32'h0;
          host_ack   <= 1'b1;
        end
      end
    end
  end

  // R10: acknowledge lasts one clock
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
  // R10: acknowledge only with the flash bus at rest
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (fl_we_n && fl_re_n && !fl_dq_oe && !seq_busy));
  // R7: arming read mode starts no strobe
  p_arm_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && op_w == OP_RDARM) |=> (fl_we_n && fl_re_n && !seq_busy));
  // R5: chip enable steady while a cycle runs
  p_ce_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && $past(seq_busy)) |-> $stable(fl_ce_n));
endmodule

// File: tb/nand_bridge_test.sv
module nand_bridge_test;
  localparam int SETUP_CLKS  = 2;
  localparam int WE_LOW_CLKS = 3;
  localparam int RE_LOW_CLKS = 3;
  localparam int HOLD_CLKS   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0, host_addr = 1'b0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic        host_ack;
  logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0]  fl_dq_o, fl_dq_i;
  logic        fl_rb_n = 1'b1;
  logic [7:0]  flash_val = 8'h3C;

  int n_cmp = 0, n_bad = 0, strobes = 0;
  logic [11:0] exp_q[$];

  always #10 clk = ~clk;

  assign fl_dq_i = fl_re_n ? 8'h00 : flash_val;

  nand_bridge #(
    .SETUP_CLKS(SETUP_CLKS), .WE_LOW_CLKS(WE_LOW_CLKS),
    .RE_LOW_CLKS(RE_LOW_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_rb_n(fl_rb_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input logic [2:0] op, input logic [7:0] b);
    return {en, op, 4'h0, b, 16'h0000};
  endfunction

  task automatic xfer(input bit we, input bit addr, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
    do @(negedge clk); while (!host_ack);
    rd = host_rdata;
    chk(fl_we_n && fl_re_n && !fl_dq_oe, "R10", {29'h0, fl_we_n, fl_re_n, fl_dq_oe}, 32'h6);
    host_req = 1'b0;
  endtask

  // Monitor: pops the expected bus cycle at each strobe fall, checks widths.
  logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;
  int we_run = 0, re_run = 0, oe_run = 0, hold_run = 0;
  bit hold_on = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      logic [11:0] e, got;
      oe_run = fl_dq_oe ? oe_run + 1 : 0;
      if (!fl_we_n) we_run++;
      if (!fl_re_n) re_run++;
      if (prev_we && !fl_we_n) begin
        strobes++;
        chk(oe_run == SETUP_CLKS + 1, "R6 setup", oe_run, SETUP_CLKS + 1);
        got = {1'b0, fl_ce_n, fl_cle, fl_ale, fl_dq_o};
        if (exp_q.size() == 0) chk(1'b0, "R2/R3/R4 unexpected WE#", {20'h0, got}, 32'h0);
        else begin e = exp_q.pop_front(); chk(got == e, "R2/R3/R4/R5 cycle", {20'h0, got}, {20'h0, e}); end
      end
      if (prev_re && !fl_re_n) begin
        strobes++;
        chk(!fl_dq_oe, "R11", {31'h0, fl_dq_oe}, 32'h0);
        got = {1'b1, fl_ce_n, fl_cle, fl_ale, 8'h00};
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected RE#", {20'h0, got}, 32'h0);
        else begin e = exp_q.pop_front(); chk(got == e, "R7 read cycle", {20'h0, got}, {20'h0, e}); end
      end
      if (!prev_we && fl_we_n) begin
        chk(we_run == WE_LOW_CLKS, "R6 WE# width", we_run, WE_LOW_CLKS);
        we_run = 0; hold_on = 1'b1; hold_run = 1;
      end else if (hold_on && fl_dq_oe && fl_we_n) hold_run++;
      if (!prev_re && fl_re_n) begin
        chk(re_run == RE_LOW_CLKS, "R6 RE# width", re_run, RE_LOW_CLKS);
        re_run = 0; flash_val = flash_val + 8'h11;
      end
      if (prev_oe && !fl_dq_oe && hold_on) begin
        chk(hold_run == HOLD_CLKS, "R6 hold", hold_run, HOLD_CLKS);
        hold_on = 1'b0;
      end
      prev_we = fl_we_n; prev_re = fl_re_n; prev_oe = fl_dq_oe;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe} == 6'b111000, "R1 pins",
        {26'h0, fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe}, 32'h38);
    xfer(0, 0, 0, r); chk(r == 32'h0, "R1 status", r, 0);

    // R2 command, R3 address, R4 data
    exp_q.push_back({1'b0, 1'b0, 1'b1, 1'b0, 8'h90});
    xfer(1, 0, word(1, 3'd0, 8'h90), r);
    exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b1, 8'h00});
    xfer(1, 0, word(1, 3'd1, 8'h00), r);
    exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, 8'hA5});
    xfer(1, 0, word(1, 3'd3, 8'hA5), r);
    exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, 8'h5A});
    xfer(1, 0, word(1, 3'd3, 8'h5A), r);

    // R5 enable low keeps CE# high
    exp_q.push_back({1'b0, 1'b1, 1'b0, 1'b0, 8'hC3});
    xfer(1, 0, word(0, 3'd3, 8'hC3), r);
    chk(fl_ce_n == 1'b1, "R5 ce off", fl_ce_n, 1);
    exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, 8'h3C});
    xfer(1, 0, word(1, 3'd3, 8'h3C), r);
    chk(fl_ce_n == 1'b0, "R5 ce on", fl_ce_n, 0);

    // R9 status fields and busy bit
    xfer(0, 0, 0, r); chk(r == 32'hB000_0000, "R9 ready", r, 32'hB000_0000);
    @(negedge clk); fl_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    xfer(0, 0, 0, r); chk(r == 32'hB000_8000, "R9 busy", r, 32'hB000_8000);
    fl_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(0, 0, 0, r); chk(r == 32'hB000_0000, "R9 ready again", r, 32'hB000_0000);

    // R8 data read before arming
    s0 = strobes;
    xfer(0, 1, 0, r); chk(r == 32'h0, "R8 data", r, 0);
    chk(strobes == s0, "R8 no strobe", strobes, s0);

    // R7 arm then read three bytes
    s0 = strobes;
    xfer(1, 0, word(1, 3'd2, 8'hFF), r);
    repeat (4) @(negedge clk);
    chk(strobes == s0, "R7 arm quiet", strobes, s0);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] e;
      e = {8'h00, flash_val, 16'h0000};
      exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 8'h00});
      xfer(0, 1, 0, r);
      chk(r == e, "R7 read byte", r, e);
    end

    // R12 writes to the data register and opcodes 4..7
    s0 = strobes;
    xfer(1, 1, word(1, 3'd3, 8'h77), r);
    repeat (4) @(negedge clk);
    chk(strobes == s0, "R12 data reg write", strobes, s0);
    xfer(0, 0, 0, r); chk(r == 32'hA000_0000, "R12 state kept", r, 32'hA000_0000);
    xfer(1, 0, word(1, 3'd5, 8'h11), r);
    repeat (4) @(negedge clk);
    chk(strobes == s0, "R12 op5 quiet", strobes, s0);
    xfer(0, 0, 0, r); chk(r == 32'hD000_0000, "R12 op stored", r, 32'hD000_0000);
    xfer(0, 1, 0, r); chk(r == 32'h0, "R12 read disarmed", r, 0);
    chk(strobes == s0, "R12 no read strobe", strobes, s0);

    // R4 writes still work after reads
    exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, 8'hE1});
    xfer(1, 0, word(1, 3'd3, 8'hE1), r);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R4 all cycles seen", exp_q.size(), 0);
    finish_run();
  end
endmodule